// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the software-facing register file of a simple serial port. A host reaches it through a 32-bit word-addressed register interface with one read strobe and one write strobe. Behind it sits a byte-wide link. Received bytes arrive with a valid strobe, and line breaks arrive as a separate event. The block holds one received character, tells the link whether it can accept another one, and emits each byte written to the transmit port with a one-cycle strobe. It does not serialise bits, generate baud rates or buffer more than one character.

Status is kept in two status words. Software clears the event bits in these words by writing ones. The ready flags follow the receive and transmit paths and cannot be cleared by software. A single level interrupt combines the status flags with their enables, which are spread over control words 1 and 4. Reading the receive word consumes the held character. Writing control word 2 with its soft-reset bit at zero returns the whole block to its initial state.

Top module: `serial_csr_block`

## Requirements
- R1: After power-on reset the word reads are: status1 0x6040 (bits 13, 14, 6), status2 0x4028 (bits 14, 5, 3), test word 0x0060 (receive-empty bit 5, transmit-empty bit 6), control1 0x0001, control2 0x0004 (transmit-enable bit 2), control3 0x0700, control4 0, baud count 4 and modulator 0. A read of the receive word returns 0x4000 (error flag bit 14). rx_ready is 1 and irq is 0.
- R2: A byte on rx_byte with rx_valid is stored only while the buffer is empty. Storing it sets receive-ready (status1 bit 9) and data-ready (status2 bit 0), clears receive-empty (test bit 5) and drops rx_ready. Bytes offered while the buffer is full are dropped.
- R3: A read of word index 0x00 while a character is held returns the character with char-ready (bit 15) set. The same read clears status1 bit 9 and status2 bit 0, sets test bit 5 and raises rx_ready. A read while the buffer is empty returns the stored value with bit 15 clear.
- R4: A break event loads the buffer with 0x5800 (break bit 11, framing bit 12, error bit 14) and sets break-detect (status2 bit 2). It follows the same acceptance rule as R2 and takes priority over a byte offered in the same cycle.
- R5: A write to status1 (index 0x25) clears only the bits set in both the written value and 0x9DB0. A write to status2 (index 0x26) clears only the bits set in both the written value and 0xBDD6. The ready and empty flags are unaffected.
- R6: irq is high exactly when (status1 & control1 & 0x2200) is nonzero, or when (status2 & mask) is nonzero. The mask holds bit 14 when control1 bit 6 is set, plus the bits of control4 & 0x0009.
- R7: A write to index 0x10 while control2 bit 2 is set produces tx_strobe for one cycle in the following cycle, with tx_byte equal to the low byte of the written value. Without that bit, nothing is emitted.
- R8: The control words (0x20 to 0x23), FIFO control (0x24), modulator (0x2A) and millisecond word (0x2C) keep the low 16 bits of a write. A write to index 0x29 loads the baud count, which reads back at 0x2B, while 0x29 itself reads as 0. Writes to the test word (0x2D) are ignored.
- R9: A write to control2 with bit 0 clear restores every register to its soft-reset state and empties the receive buffer. The soft-reset state is the R1 state, except that control1 becomes 0. Control2 then holds the written low 16 bits with bit 0 forced to 1.
- R10: A read of an undefined index, or a write to one (including 0x00 and 0x2B), returns 0 and changes nothing. bus_err is high in the same cycle as the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_addr | input | ADDR_W | Byte address; word index is bus_addr >> 2 |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rd is high |
| bus_err | output | 1 | Access to an undefined index |
| rx_byte | input | CHAR_W | Received byte |
| rx_valid | input | 1 | rx_byte is offered this cycle |
| rx_break | input | 1 | Break event this cycle |
| rx_ready | output | 1 | Receive buffer can accept a byte |
| tx_byte | output | CHAR_W | Byte to send |
| tx_strobe | output | 1 | tx_byte is valid this cycle |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle and that each access lasts one cycle. They also take a soft reset to win over any receive event in the same cycle. The bench drives every access as a single-cycle pulse set up on the falling edge, never overlaps the two strobes, and offers bytes or breaks only between bus accesses, except in the one deliberate break-plus-byte collision. The interrupt checks sweep all 64 combinations of the five enable bits and the buffer state. The error checks read every one of the 1024 word indices.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;

   localparam int REG_W = 16;

   // word indices (byte address >> 2)
   localparam int IX_RXD   = 'h00;
   localparam int IX_TXD   = 'h10;
   localparam int IX_C1    = 'h20;
   localparam int IX_C2    = 'h21;
   localparam int IX_C3    = 'h22;
   localparam int IX_C4    = 'h23;
   localparam int IX_FC    = 'h24;
   localparam int IX_S1    = 'h25;
   localparam int IX_S2    = 'h26;
   localparam int IX_BINC  = 'h29;
   localparam int IX_BMOD  = 'h2A;
   localparam int IX_BCNT  = 'h2B;
   localparam int IX_ONEMS = 'h2C;
   localparam int IX_TEST  = 'h2D;

   // status1 / control1 shared positions
   localparam int B_TRDY    = 13;
   localparam int B_RRDY    = 9;
   localparam int B_TXMTYEN = 6;
   // status2 positions
   localparam int B_RDR  = 0;
   localparam int B_BRCD = 2;
   localparam int B_TXFE = 14;
   // control2
   localparam int B_SRST = 0;
   localparam int B_TXEN = 2;
   // test word
   localparam int B_RXEMPTY = 5;
   localparam int B_TXEMPTY = 6;
   // receive word flags
   localparam int B_CHRDY = 15;

   localparam logic [REG_W-1:0] S1_CLR_MASK = 16'h9DB0;
   localparam logic [REG_W-1:0] S2_CLR_MASK = 16'hBDD6;
   localparam logic [REG_W-1:0] C4_IRQ_MASK = 16'h0009;

   localparam logic [REG_W-1:0] S1_RST   = 16'h6040;
   localparam logic [REG_W-1:0] S2_RST   = 16'h4028;
   localparam logic [REG_W-1:0] C1_POR   = 16'h0001;
   localparam logic [REG_W-1:0] C2_POR   = 16'h0004;
   localparam logic [REG_W-1:0] C3_RST   = 16'h0700;
   localparam logic [REG_W-1:0] BCNT_RST = 16'h0004;
   localparam logic [REG_W-1:0] RXB_RST  = 16'h4000;
   localparam logic [REG_W-1:0] BRK_WORD = 16'h5800;

   typedef enum logic [3:0] {
      RID_RXD, RID_TXD, RID_C1, RID_C2, RID_C3, RID_C4, RID_FC, RID_S1,
      RID_S2, RID_BINC, RID_BMOD, RID_BCNT, RID_ONEMS, RID_TEST, RID_NONE
   } reg_id_e;

endpackage

// File: rtl/serial_csr_decode.sv
module serial_csr_decode
   import serial_csr_pkg::*;
#(
   parameter int IDX_W = 10
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             rd,
   input  logic             wr,
   output reg_id_e          rid,
   output logic             rd_ok,
   output logic             wr_ok,
   output logic             err
);

   generate
      if (IDX_W < 6) begin : g_bad_idx
         $error("serial_csr_decode: IDX_W must be at least 6");
      end
   endgenerate

   always_comb begin
      case (idx)
         IDX_W'(IX_RXD):   rid = RID_RXD;
         IDX_W'(IX_TXD):   rid = RID_TXD;
         IDX_W'(IX_C1):    rid = RID_C1;
         IDX_W'(IX_C2):    rid = RID_C2;
         IDX_W'(IX_C3):    rid = RID_C3;
         IDX_W'(IX_C4):    rid = RID_C4;
         IDX_W'(IX_FC):    rid = RID_FC;
         IDX_W'(IX_S1):    rid = RID_S1;
         IDX_W'(IX_S2):    rid = RID_S2;
         IDX_W'(IX_BINC):  rid = RID_BINC;
         IDX_W'(IX_BMOD):  rid = RID_BMOD;
         IDX_W'(IX_BCNT):  rid = RID_BCNT;
         IDX_W'(IX_ONEMS): rid = RID_ONEMS;
         IDX_W'(IX_TEST):  rid = RID_TEST;
         default:          rid = RID_NONE;
      endcase
   end

   assign rd_ok = (rid != RID_NONE) && (rid != RID_TXD);
   assign wr_ok = (rid != RID_NONE) && (rid != RID_RXD) && (rid != RID_BCNT);
   assign err   = (rd & ~rd_ok) | (wr & ~wr_ok);

endmodule

// File: rtl/serial_csr_rxhold.sv
module serial_csr_rxhold
   import serial_csr_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              char_valid,
   input  logic [CHAR_W-1:0] char_in,
   input  logic              brk,
   input  logic              consume,
   output logic [REG_W-1:0]  hold,
   output logic              empty,
   output logic              took,
   output logic              took_brk,
   output logic              drained
);

   generate
      if (CHAR_W < 1 || CHAR_W > 8) begin : g_bad_char
         $error("serial_csr_rxhold: CHAR_W must be 1..8");
      end
   endgenerate

   logic [REG_W-1:0] load_val;

   assign took     = (char_valid | brk) & empty & ~soft_rst;
   assign took_brk = took & brk;
   assign drained  = consume & ~empty & ~soft_rst;
   assign load_val = brk ? BRK_WORD : {{(REG_W-CHAR_W){1'b0}}, char_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold  <= RXB_RST;
         empty <= 1'b1;
      end else if (soft_rst) begin
         hold  <= RXB_RST;
         empty <= 1'b1;
      end else if (took) begin
         hold  <= load_val;
         empty <= 1'b0;
      end else if (drained) begin
         empty <= 1'b1;
      end
   end

   // R2: a full buffer keeps its contents until consumed or reset
   assert_hold_when_full_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !soft_rst && !consume) |=> ($stable(hold) && !empty));

   // R3: consuming a held character empties the buffer
   assert_consume_empties_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (consume && !empty && !soft_rst) |=> empty);

   // R4: a break accepted into an empty buffer stores the break word
   assert_break_word_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (brk && empty && !soft_rst) |=> (hold == BRK_WORD));

endmodule

// File: rtl/serial_csr_irq.sv
module serial_csr_irq
   import serial_csr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] stat1,
   input  logic [REG_W-1:0] stat2,
   input  logic [REG_W-1:0] ctrl1,
   input  logic [REG_W-1:0] ctrl4,
   output logic             irq
);

   logic [REG_W-1:0] ready_bits;
   logic [REG_W-1:0] s2_mask;

   always_comb begin
      ready_bits = '0;
      ready_bits[B_TRDY] = 1'b1;
      ready_bits[B_RRDY] = 1'b1;
      s2_mask = ctrl4 & C4_IRQ_MASK;
      s2_mask[B_TXFE] = s2_mask[B_TXFE] | ctrl1[B_TXMTYEN];
   end

   assign irq = (|(stat1 & ctrl1 & ready_bits)) | (|(stat2 & s2_mask));

   // R6: with every enable cleared the line stays low
   assert_irq_quiet_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl1[B_TRDY] && !ctrl1[B_RRDY] && !ctrl1[B_TXMTYEN] && ((ctrl4 & C4_IRQ_MASK) == '0))
      |-> !irq);

endmodule

// File: rtl/serial_csr_block.sv
module serial_csr_block
   import serial_csr_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   input  logic [CHAR_W-1:0] rx_byte,
   input  logic              rx_valid,
   input  logic              rx_break,
   output logic              rx_ready,
   output logic [CHAR_W-1:0] tx_byte,
   output logic              tx_strobe,
   output logic              irq
);

   localparam int IDX_W = ADDR_W - 2;

   generate
      if (DATA_W <= REG_W) begin : g_bad_data
         $error("serial_csr_block: DATA_W must exceed the 16-bit register width");
      end
   endgenerate

   reg_id_e          rid;
   logic             rd_ok, wr_ok;
   logic [REG_W-1:0] wv;
   logic             soft_rst, rx_consume;
   logic [REG_W-1:0] rx_hold;
   logic             rx_empty, rx_took, rx_took_brk, rx_drained;
   logic [REG_W-1:0] c1, c2, c3, c4, fc, bmod, bcnt, onems, s1, s2;
   logic [REG_W-1:0] s1_clr, s2_clr, s1_nxt, s2_nxt, test_w, rd_val;
   logic             unused_ok;

   assign wv         = bus_wdata[REG_W-1:0];
   assign unused_ok  = ^{bus_wdata[DATA_W-1:REG_W], bus_addr[1:0]};
   assign soft_rst   = bus_wr & (rid == RID_C2) & ~wv[B_SRST];
   assign rx_consume = bus_rd & (rid == RID_RXD);

   serial_csr_decode #(.IDX_W(IDX_W)) u_dec (
      .idx   (bus_addr[ADDR_W-1:2]),
      .rd    (bus_rd),
      .wr    (bus_wr),
      .rid   (rid),
      .rd_ok (rd_ok),
      .wr_ok (wr_ok),
      .err   (bus_err)
   );

   serial_csr_rxhold #(.CHAR_W(CHAR_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .char_valid (rx_valid),
      .char_in    (rx_byte),
      .brk        (rx_break),
      .consume    (rx_consume),
      .hold       (rx_hold),
      .empty      (rx_empty),
      .took       (rx_took),
      .took_brk   (rx_took_brk),
      .drained    (rx_drained)
   );

   // per-bit write-one-to-clear enables
   generate
      for (genvar gi = 0; gi < REG_W; gi++) begin : g_w1c
         assign s1_clr[gi] = bus_wr & (rid == RID_S1) & wv[gi] & S1_CLR_MASK[gi];
         assign s2_clr[gi] = bus_wr & (rid == RID_S2) & wv[gi] & S2_CLR_MASK[gi];
      end
   endgenerate

   always_comb begin
      s1_nxt = s1 & ~s1_clr;
      s2_nxt = s2 & ~s2_clr;
      if (rx_drained) begin
         s1_nxt[B_RRDY] = 1'b0;
         s2_nxt[B_RDR]  = 1'b0;
      end
      if (rx_took) begin
         s1_nxt[B_RRDY] = 1'b1;
         s2_nxt[B_RDR]  = 1'b1;
      end
      if (rx_took_brk) s2_nxt[B_BRCD] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c1 <= C1_POR;  c2 <= C2_POR;  c3 <= C3_RST;  c4 <= '0;
         fc <= '0;  bmod <= '0;  bcnt <= BCNT_RST;  onems <= '0;
         s1 <= S1_RST;  s2 <= S2_RST;
      end else if (soft_rst) begin
         c1 <= '0;  c2 <= wv | (REG_W'(1) << B_SRST);  c3 <= C3_RST;  c4 <= '0;
         fc <= '0;  bmod <= '0;  bcnt <= BCNT_RST;  onems <= '0;
         s1 <= S1_RST;  s2 <= S2_RST;
      end else begin
         if (bus_wr) begin
            case (rid)
               RID_C1:    c1    <= wv;
               RID_C2:    c2    <= wv;
               RID_C3:    c3    <= wv;
               RID_C4:    c4    <= wv;
               RID_FC:    fc    <= wv;
               RID_BINC:  bcnt  <= wv;
               RID_BMOD:  bmod  <= wv;
               RID_ONEMS: onems <= wv;
               default: ;
            endcase
         end
         s1 <= s1_nxt;
         s2 <= s2_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_strobe <= 1'b0;
         tx_byte   <= '0;
      end else begin
         tx_strobe <= bus_wr & (rid == RID_TXD) & c2[B_TXEN];
         if (bus_wr && rid == RID_TXD && c2[B_TXEN]) tx_byte <= bus_wdata[CHAR_W-1:0];
      end
   end

   always_comb begin
      test_w = '0;
      test_w[B_TXEMPTY] = 1'b1;
      test_w[B_RXEMPTY] = rx_empty;
   end

   always_comb begin
      case (rid)
         RID_RXD:   rd_val = rx_hold | (REG_W'(!rx_empty) << B_CHRDY);
         RID_C1:    rd_val = c1;
         RID_C2:    rd_val = c2;
         RID_C3:    rd_val = c3;
         RID_C4:    rd_val = c4;
         RID_FC:    rd_val = fc;
         RID_S1:    rd_val = s1;
         RID_S2:    rd_val = s2;
         RID_BMOD:  rd_val = bmod;
         RID_BCNT:  rd_val = bcnt;
         RID_ONEMS: rd_val = onems;
         RID_TEST:  rd_val = test_w;
         default:   rd_val = '0;
      endcase
   end

   assign bus_rdata = (bus_rd && rd_ok) ? {{(DATA_W-REG_W){1'b0}}, rd_val} : '0;
   assign rx_ready  = ~s1[B_RRDY];

   serial_csr_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .stat1 (s1),
      .stat2 (s2),
      .ctrl1 (c1),
      .ctrl4 (c4),
      .irq   (irq)
   );

   // R2: receive-ready status mirrors the buffer held by the receive path
   assert_ready_mirror_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      s1[B_RRDY] == !rx_empty);

   // R5: a status1 write never touches the ready flags
   assert_w1c_ready_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && rid == RID_S1 && !rx_took && !rx_drained)
      |=> (s1[B_RRDY] == $past(s1[B_RRDY]) && s1[B_TRDY] == $past(s1[B_TRDY])));

   // R7: every transmit strobe follows an enabled transmit write
   assert_tx_gate_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      tx_strobe |-> $past(bus_wr && rid == RID_TXD && c2[B_TXEN]));

   // R9: soft reset leaves control2 with its reset bit set and the buffer empty
   assert_soft_reset_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (c2[B_SRST] && c3 == C3_RST && rx_empty));

   // R10: an undefined access returns zero
   assert_err_zero_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rdata == '0));

endmodule

// File: tb/serial_csr_block_bench.sv
module serial_csr_block_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [7:0]  rx_byte = '0;
   logic        rx_valid = 1'b0, rx_break = 1'b0;
   logic        rx_ready;
   logic [7:0]  tx_byte;
   logic        tx_strobe;
   logic        irq;

   int checks = 0, errors = 0, cycles = 0;
   logic [31:0] rv;
   logic        re, we;

   always #5 clk = ~clk;

   serial_csr_block u_serial_csr_block (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_break(rx_break), .rx_ready(rx_ready),
      .tx_byte(tx_byte), .tx_strobe(tx_strobe), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      bus_addr = 12'(idx << 2); bus_wdata = d; bus_wr = 1'b1;
      #1 we = bus_err;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int idx);
      bus_addr = 12'(idx << 2); bus_rd = 1'b1;
      #1 rv = bus_rdata; re = bus_err;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic push(input logic [7:0] b, input logic brk);
      rx_byte = b; rx_valid = 1'b1; rx_break = brk;
      @(negedge clk);
      rx_valid = 1'b0; rx_break = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 power-on state
      chk("R1 rx_ready", rx_ready, 1);
      chk("R1 irq", irq, 0);
      chk("R1 tx_strobe", tx_strobe, 0);
      rd('h25); chk("R1 status1", rv, 32'h6040);
      rd('h26); chk("R1 status2", rv, 32'h4028);
      rd('h2D); chk("R1 test", rv, 32'h0060);
      rd('h20); chk("R1 ctrl1", rv, 32'h0001);
      rd('h21); chk("R1 ctrl2", rv, 32'h0004);
      rd('h22); chk("R1 ctrl3", rv, 32'h0700);
      rd('h23); chk("R1 ctrl4", rv, 0);
      rd('h2B); chk("R1 baud count", rv, 4);
      rd('h2A); chk("R1 modulator", rv, 0);
      rd('h00); chk("R1 rx word", rv, 32'h4000);

      // R8 storage width and special words
      wr('h22, 32'hABCD1234); rd('h22); chk("R8 ctrl3 low half", rv, 32'h1234);
      wr('h24, 32'hFFFF0055); rd('h24); chk("R8 fifo ctrl", rv, 32'h0055);
      wr('h2C, 32'h0001BEEF); rd('h2C); chk("R8 ms word", rv, 32'hBEEF);
      wr('h2A, 32'h00030042); rd('h2A); chk("R8 modulator", rv, 32'h0042);
      wr('h29, 32'h00010777); rd('h2B); chk("R8 baud count via 0x29", rv, 32'h0777);
      rd('h29); chk("R8 incremental reads 0", rv, 0);
      chk("R8 incremental no err", re, 0);
      wr('h2D, 32'h0000FFFF); chk("R8 test write no err", we, 0);
      rd('h2D); chk("R8 test write ignored", rv, 32'h0060);

      // R7 transmit
      wr('h10, 32'h000001A5);
      chk("R7 strobe", tx_strobe, 1);
      chk("R7 byte", tx_byte, 8'hA5);
      @(negedge clk); chk("R7 strobe one cycle", tx_strobe, 0);
      wr('h21, 32'h0001);
      wr('h10, 32'h0000005A);
      chk("R7 disabled no strobe", tx_strobe, 0);
      wr('h21, 32'h0005);
      wr('h10, 32'h0000003C);
      chk("R7 re-enabled byte", tx_byte, 8'h3C);
      rd('h25); chk("R7 status1 after tx", rv, 32'h6040);

      // R2 / R3 receive path
      push(8'h3C, 1'b0);
      chk("R2 rx_ready low", rx_ready, 0);
      rd('h25); chk("R2 status1", rv, 32'h6240);
      rd('h26); chk("R2 status2", rv, 32'h4029);
      rd('h2D); chk("R2 test", rv, 32'h0040);
      push(8'h77, 1'b0);
      rd('h00); chk("R2 R3 full read keeps first byte", rv, 32'h803C);
      chk("R3 rx_ready high", rx_ready, 1);
      rd('h25); chk("R3 status1", rv, 32'h6040);
      rd('h26); chk("R3 status2", rv, 32'h4028);
      rd('h2D); chk("R3 test", rv, 32'h0060);
      rd('h00); chk("R3 empty read no char-ready", rv, 32'h003C);

      // R4 break with simultaneous byte
      push(8'h11, 1'b1);
      rd('h26); chk("R4 status2 break detect", rv, 32'h402D);
      rd('h00); chk("R4 break word", rv, 32'hD800);
      rd('h26); chk("R4 status2 after read", rv, 32'h402C);

      // R5 write-one-to-clear
      push(8'h42, 1'b0);
      wr('h25, 32'hFFFF); rd('h25); chk("R5 status1 unchanged", rv, 32'h6240);
      wr('h26, 32'hFFFF); rd('h26); chk("R5 status2 only event bits", rv, 32'h4029);
      rd('h00); chk("R5 byte survives", rv, 32'h8042);

      // R6 interrupt sweep
      for (int full = 0; full < 2; full++) begin
         if (full == 1) push(8'h5E, 1'b0);
         for (int k = 0; k < 32; k++) begin
            logic t, r, m, tc, dr, exp_irq;
            t = k[0]; r = k[1]; m = k[2]; tc = k[3]; dr = k[4];
            wr('h23, {28'd0, tc, 2'b00, dr});
            wr('h20, 32'h1 | (32'(t) << 13) | (32'(r) << 9) | (32'(m) << 6));
            exp_irq = t | (r & full[0]) | m | tc | (dr & full[0]);
            chk($sformatf("R6 irq k=%0d full=%0d", k, full), irq, exp_irq);
         end
         if (full == 1) rd('h00);
      end

      // R9 soft reset
      wr('h23, 32'h9); wr('h24, 32'h7); wr('h2C, 32'h33);
      push(8'h99, 1'b0);
      wr('h21, 32'h0006);
      chk("R9 rx_ready", rx_ready, 1);
      chk("R9 irq", irq, 0);
      rd('h21); chk("R9 ctrl2 forced bit", rv, 32'h0007);
      rd('h20); chk("R9 ctrl1", rv, 0);
      rd('h22); chk("R9 ctrl3", rv, 32'h0700);
      rd('h23); chk("R9 ctrl4", rv, 0);
      rd('h24); chk("R9 fifo ctrl", rv, 0);
      rd('h2C); chk("R9 ms word", rv, 0);
      rd('h2B); chk("R9 baud count", rv, 4);
      rd('h25); chk("R9 status1", rv, 32'h6040);
      rd('h26); chk("R9 status2", rv, 32'h4028);
      rd('h2D); chk("R9 test", rv, 32'h0060);
      rd('h00); chk("R9 rx word", rv, 32'h4000);

      // R10 undefined indices
      for (int i = 0; i < 1024; i++) begin
         logic def;
         def = (i == 0) || (i >= 'h20 && i <= 'h26) || (i >= 'h29 && i <= 'h2D);
         rd(i);
         chk($sformatf("R10 err idx=0x%0h", i), re, !def);
         if (!def) chk($sformatf("R10 zero idx=0x%0h", i), rv, 0);
      end
      wr('h2B, 32'h55); chk("R10 write count word err", we, 1);
      rd('h2B); chk("R10 count unchanged", rv, 4);
      wr('h00, 32'h12); chk("R10 write rx word err", we, 1);
      rd('h00); chk("R10 rx unchanged", rv, 32'h4000);
      wr('h27, 32'hFFFF); chk("R10 write gap err", we, 1);
      rd('h20); chk("R10 ctrl1 unchanged", rv, 0);

      finish_run();
   end

endmodule